// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns pointer events into the five-byte packet used by a classic serial mouse and holds the bytes in a small circular queue. A receive-data consumer reads them one at a time. Each event strobe carries a signed horizontal motion, a signed vertical motion and three button flags. The encoder builds a start byte with active-low button bits and saturates both motion values to ±127. It reverses the vertical axis, then appends two zero bytes. All five bytes are written into the queue in the cycle that follows the strobe.

The consumer sees a byte-available flag and the byte at the head of the queue. It asserts a pop request to take that byte away. When the queue is empty the read port shows zero and a pop does nothing. When the queue lacks room, the bytes that do not fit are lost without notice. A synchronous clear input empties the queue.

Top module: `mouse_pkt_enc`

## Requirements
- R1: Each accepted event appends five bytes in this order: start byte, X motion byte, Y motion byte, 0x00, 0x00.
- R2: The start byte is 0x87 when no button is pressed. A pressed left button clears bit 2, a pressed middle button clears bit 1 and a pressed right button clears bit 0.
- R3: The X motion byte is the signed horizontal input saturated to -127..+127, given as its low 8 bits in two's complement. Inputs of -128 or below give 0x81, and inputs of +128 or above give 0x7F.
- R4: The Y motion byte is the negated vertical input saturated to -127..+127 in the same encoding. An input of +3 gives 0xFD, and an input of -512 gives 0x7F.
- R5: When the queue is full, an event adds nothing and the stored bytes are unchanged. Occupancy never exceeds DEPTH.
- R6: While the queue is empty, the read port shows 0x00, and a pop request removes nothing and changes nothing.
- R7: The byte-available flag is high exactly when the queue holds at least one byte. It stays high after a pop for as long as bytes remain.
- R8: When fewer than five entries are free, the leading bytes of the packet fill the free entries in packet order and the rest are dropped.
- R9: An event and a pop in the same cycle both take effect. Free space for the event is measured on the occupancy before that cycle.
- R10: The clear input empties the queue by the next clock edge and takes priority over an event or a pop in the same cycle.
- R11: After reset the queue is empty, the byte-available flag is low and the read port shows 0x00.
- R12: Read and write positions wrap modulo DEPTH, so bytes come out in arrival order across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous queue flush |
| evtValid | input | 1 | Pointer event strobe, one cycle per event |
| evtDx | input | MOT_W | Signed horizontal motion |
| evtDy | input | MOT_W | Signed vertical motion |
| btnLeft | input | 1 | Left button pressed |
| btnMiddle | input | 1 | Middle button pressed |
| btnRight | input | 1 | Right button pressed |
| popReq | input | 1 | Remove the head byte |
| byteAvail | output | 1 | Queue holds at least one byte |
| popData | output | 8 | Head byte, 0x00 when empty |

## Verification
The assertions assume that clear, evtValid and popReq are synchronous single-cycle levels with known values from reset onward. They also assume that an event strobe describes one complete event. The stimulus changes every input only on the falling clock edge. Each event strobe lasts exactly one cycle, so an event is never counted twice. The same-cycle event-and-pop case is entered only from a known occupancy, which keeps the occupancy arithmetic the checker expects within a range where no byte is dropped.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;
  localparam int PKT_LEN = 5;
  localparam int PCNT_W  = 3;

  typedef struct packed {
    logic [PCNT_W-1:0] pushCnt;
    logic              pop;
    logic              clr;
  } qStrobe_t;

  function automatic logic [7:0] satByte(input int v);
    if (v > 127)       return 8'h7f;
    else if (v < -127) return 8'h81;
    else               return 8'(v);
  endfunction
endpackage

// File: rtl/mouse_pkt_ctrl.sv
module mouse_pkt_ctrl
  import mouse_pkt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int MOT_W = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clear,
  input  logic                    evtValid,
  input  logic signed [MOT_W-1:0] evtDx,
  input  logic signed [MOT_W-1:0] evtDy,
  input  logic                    btnLeft,
  input  logic                    btnMiddle,
  input  logic                    btnRight,
  input  logic                    popReq,
  input  logic [CNT_W-1:0]        occupancy,
  output qStrobe_t                strobe,
  output logic [PKT_LEN-1:0][7:0] pktBytes
);
  logic [CNT_W-1:0] freeSlots;
  logic [PCNT_W-1:0] fitCnt;
  int dxVal;
  int dyNeg;

  always_comb begin
    dxVal = int'(evtDx);
    dyNeg = -int'(evtDy);
    pktBytes[0] = {5'b10000, ~btnLeft, ~btnMiddle, ~btnRight};
    pktBytes[1] = satByte(dxVal);
    pktBytes[2] = satByte(dyNeg);
    pktBytes[3] = 8'h00;
    pktBytes[4] = 8'h00;
  end

  always_comb begin
    freeSlots = CNT_W'(DEPTH) - occupancy;
    if (freeSlots < CNT_W'(PKT_LEN)) fitCnt = PCNT_W'(freeSlots);
    else                             fitCnt = PCNT_W'(PKT_LEN);
    strobe.clr     = clear;
    strobe.pushCnt = (evtValid && !clear) ? fitCnt : '0;
    strobe.pop     = popReq && (occupancy != '0) && !clear;
  end
endmodule

// File: rtl/mouse_pkt_queue.sv
module mouse_pkt_queue
  import mouse_pkt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  qStrobe_t                strobe,
  input  logic [PKT_LEN-1:0][7:0] pktBytes,
  output logic [7:0]              popData,
  output logic                    byteAvail,
  output logic [CNT_W-1:0]        occupancy
);
  logic [7:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] base, input int step);
    int sum;
    sum = int'(base) + step;
    if (sum >= DEPTH) sum = sum - DEPTH;
    return PTR_W'(sum);
  endfunction

  always_ff @(posedge clk) begin
    if (!strobe.clr) begin
      for (int k = 0; k < PKT_LEN; k++) begin
        if (k < int'(strobe.pushCnt)) store[wrapAdd(wrPtr, k)] <= pktBytes[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (strobe.clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrapAdd(wrPtr, int'(strobe.pushCnt));
      if (strobe.pop) rdPtr <= wrapAdd(rdPtr, 1);
      count <= count + CNT_W'(strobe.pushCnt) - CNT_W'(strobe.pop);
    end
  end

  assign byteAvail = (count != '0);
  assign popData   = byteAvail ? store[rdPtr] : 8'h00;
  assign occupancy = count;
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mouse_pkt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int MOT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    evtValid,
  input  logic signed [MOT_W-1:0] evtDx,
  input  logic signed [MOT_W-1:0] evtDy,
  input  logic                    btnLeft,
  input  logic                    btnMiddle,
  input  logic                    btnRight,
  input  logic                    popReq,
  output logic                    byteAvail,
  output logic [7:0]              popData
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  qStrobe_t                strobe;
  logic [PKT_LEN-1:0][7:0] pktBytes;
  logic [CNT_W-1:0]        occupancy;

  mouse_pkt_ctrl #(.DEPTH(DEPTH), .MOT_W(MOT_W)) uCtrl (
    .clear(clear), .evtValid(evtValid), .evtDx(evtDx), .evtDy(evtDy),
    .btnLeft(btnLeft), .btnMiddle(btnMiddle), .btnRight(btnRight),
    .popReq(popReq), .occupancy(occupancy), .strobe(strobe), .pktBytes(pktBytes)
  );

  mouse_pkt_queue #(.DEPTH(DEPTH)) uQueue (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pktBytes(pktBytes),
    .popData(popData), .byteAvail(byteAvail), .occupancy(occupancy)
  );
endmodule

// File: rtl/mouse_pkt_enc_chk.sv
module mouse_pkt_enc_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             evtValid,
  input logic             popReq,
  input logic             byteAvail,
  input logic [7:0]       popData,
  input logic [CNT_W-1:0] occupancy
);
  p_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH);

  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occupancy) == DEPTH && evtValid && !popReq && !clear) |=> $stable(occupancy));

  p_empty_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !byteAvail |-> popData == 8'h00);

  p_pop_keeps_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (popReq && occupancy > CNT_W'(1) && !clear) |=> byteAvail);

  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!byteAvail && occupancy == '0));

  p_start_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && occupancy == '0 && !clear) |=> popData[7:3] == 5'b10000);

  p_event_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && popReq && !clear && occupancy != '0 && int'(occupancy) <= DEPTH - 5)
      |=> int'(occupancy) == int'($past(occupancy)) + 4);
endmodule

bind mouse_pkt_enc mouse_pkt_enc_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .evtValid(evtValid), .popReq(popReq),
  .byteAvail(byteAvail), .popData(popData), .occupancy(occupancy)
);

// File: tb/mouse_pkt_enc_test.sv
module mouse_pkt_enc_test;
  localparam int MOT_W = 10;
  localparam int DEPTH = 16;
  localparam int NVEC  = 8;

  // {dx, dy, left, middle, right, b0, b1, b2}
  typedef struct packed {
    logic signed [MOT_W-1:0] dx;
    logic signed [MOT_W-1:0] dy;
    logic [2:0]              btn;
    logic [7:0]              b0;
    logic [7:0]              b1;
    logic [7:0]              b2;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{10'sd0,    10'sd0,    3'b000, 8'h87, 8'h00, 8'h00},
    '{10'sd5,    10'sd3,    3'b100, 8'h83, 8'h05, 8'hfd},
    '{10'sd200,  -10'sd300, 3'b010, 8'h85, 8'h7f, 8'h7f},
    '{-10'sd128, 10'sd128,  3'b001, 8'h86, 8'h81, 8'h81},
    '{-10'sd512, -10'sd512, 3'b111, 8'h80, 8'h81, 8'h7f},
    '{10'sd127,  -10'sd127, 3'b000, 8'h87, 8'h7f, 8'h7f},
    '{-10'sd127, 10'sd127,  3'b000, 8'h87, 8'h81, 8'h81},
    '{10'sd511,  10'sd511,  3'b101, 8'h82, 8'h7f, 8'h81}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic clear = 0;
  logic evtValid = 0;
  logic signed [MOT_W-1:0] evtDx = '0;
  logic signed [MOT_W-1:0] evtDy = '0;
  logic btnLeft = 0, btnMiddle = 0, btnRight = 0;
  logic popReq = 0;
  logic byteAvail;
  logic [7:0] popData;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mouse_pkt_enc #(.DEPTH(DEPTH), .MOT_W(MOT_W)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .evtValid(evtValid),
    .evtDx(evtDx), .evtDy(evtDy), .btnLeft(btnLeft), .btnMiddle(btnMiddle),
    .btnRight(btnRight), .popReq(popReq), .byteAvail(byteAvail), .popData(popData)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sendEvt(input logic signed [MOT_W-1:0] dx, input logic signed [MOT_W-1:0] dy,
                         input logic [2:0] btn, input logic withPop);
    evtValid = 1; evtDx = dx; evtDy = dy;
    {btnLeft, btnMiddle, btnRight} = btn;
    popReq = withPop;
    tick();
    evtValid = 0; popReq = 0;
  endtask

  task automatic popChk(input logic [7:0] exp, input string tag);
    check(byteAvail === 1'b1, {tag, " avail"}, int'(byteAvail), 1);
    check(popData === exp, tag, int'(popData), int'(exp));
    popReq = 1;
    tick();
    popReq = 0;
  endtask

  task automatic emptyChk(input string tag);
    check(byteAvail === 1'b0, {tag, " avail"}, int'(byteAvail), 0);
    check(popData === 8'h00, {tag, " data"}, int'(popData), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    emptyChk("R11 reset");

    // R1..R4, R12: table walk, 40 bytes through a 16-entry queue wraps the pointers
    for (int i = 0; i < NVEC; i++) begin
      sendEvt(VECS[i].dx, VECS[i].dy, VECS[i].btn, 1'b0);
      popChk(VECS[i].b0, $sformatf("R2 vec%0d start", i));
      popChk(VECS[i].b1, $sformatf("R3 vec%0d dx", i));
      popChk(VECS[i].b2, $sformatf("R4 vec%0d dy", i));
      popChk(8'h00, $sformatf("R1 vec%0d pad0 R12", i));
      popChk(8'h00, $sformatf("R1 vec%0d pad1 R12", i));
      emptyChk($sformatf("R7 vec%0d drained", i));
    end

    // R6: pop on empty changes nothing
    popReq = 1; tick(); popReq = 0;
    emptyChk("R6 empty pop");
    sendEvt(10'sd1, 10'sd0, 3'b000, 1'b0);
    popChk(8'h87, "R6 order after empty pop");
    popChk(8'h01, "R6 dx after empty pop");
    popChk(8'h00, "R6 dy after empty pop");
    popChk(8'h00, "R6 pad0");
    popChk(8'h00, "R6 pad1");

    // R8, R5: three events fill 15, fourth fits one byte, fifth dropped
    sendEvt(10'sd1, 10'sd1, 3'b000, 1'b0);
    sendEvt(10'sd2, 10'sd2, 3'b000, 1'b0);
    sendEvt(10'sd3, 10'sd3, 3'b000, 1'b0);
    sendEvt(10'sd9, 10'sd9, 3'b100, 1'b0);
    sendEvt(10'sd7, 10'sd7, 3'b001, 1'b0);
    for (int e = 1; e <= 3; e++) begin
      popChk(8'h87, $sformatf("R5 ev%0d start", e));
      popChk(8'(e), $sformatf("R5 ev%0d dx", e));
      popChk(8'(-e), $sformatf("R5 ev%0d dy", e));
      popChk(8'h00, "R5 pad0");
      popChk(8'h00, "R5 pad1");
    end
    popChk(8'h83, "R8 partial start byte");
    emptyChk("R8 rest dropped R5");

    // R9: event and pop together
    sendEvt(10'sd4, 10'sd0, 3'b000, 1'b0);
    sendEvt(10'sd6, -10'sd2, 3'b010, 1'b1);
    popChk(8'h04, "R9 first event dx");
    popChk(8'h00, "R9 first event dy");
    popChk(8'h00, "R9 pad0");
    popChk(8'h00, "R9 pad1");
    popChk(8'h85, "R9 second start");
    popChk(8'h06, "R9 second dx");
    popChk(8'h02, "R9 second dy");
    popChk(8'h00, "R9 second pad0");
    popChk(8'h00, "R9 second pad1");
    emptyChk("R9 drained");

    // R10: clear wins over a same-cycle event and pop
    sendEvt(10'sd1, 10'sd1, 3'b000, 1'b0);
    sendEvt(10'sd1, 10'sd1, 3'b000, 1'b0);
    clear = 1; evtValid = 1; popReq = 1;
    tick();
    clear = 0; evtValid = 0; popReq = 0;
    emptyChk("R10 clear");
    sendEvt(10'sd0, 10'sd0, 3'b111, 1'b0);
    popChk(8'h80, "R10 refill after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule